// File: doc/BRIEF.md
# Pin Input Glitch Filter and Edge Interrupt Unit

This block conditions a bank of already-synchronized input pins (32 by default) and turns their transitions into interrupt and event signals. Each pin can run through an optional glitch filter that rejects one-cycle spikes and accepts pulses of two cycles or more. The filter costs a fixed two cycles of extra latency. A per-pin two-bit trigger mode picks any change, rising edge only or falling edge only. A detected edge sets a sticky per-pin flag. The flags, masked by a per-pin interrupt enable, are ORed into a single registered interrupt request.

A second path turns the same qualified edge into a one-cycle event pulse on a per-pin output. It is gated by its own enable. A per-pin selector decides whether the event path takes its edges from the filtered level or from the raw level, independently of the filter choice made for the interrupt path.

All configuration lives in six per-pin vector registers plus the flag vector. These are reached over a simple synchronous write bus with combinational read data. Every register has a plain-write, a bit-set and a bit-clear alias, so software can change single pins without a read-modify-write sequence.

Top module: `pin_irq_conditioner`

## Requirements
- R1: After reset every register reads 0, irq_o is 0 and evt_o is all zero; addresses whose register field is 7 read 0.
- R2: The address is split as register = bus_addr[4:2], operation = bus_addr[1:0]. The registers are 0 filter enable, 1 mode low plane, 2 mode high plane, 3 interrupt enable, 4 event enable, 5 event-filter select and 6 flags. Operation 0 writes the whole value, 1 ORs in the ones of bus_wdata, 2 clears the bits where bus_wdata is 1, and 3 changes nothing. On the flag register, operation 0 is ignored. Each write takes effect at the clock edge where bus_we is sampled high.
- R3: The trigger mode of pin i is {mode-high[i], mode-low[i]}. Code 00 fires on any change, 01 on a rising edge, 10 on a falling edge, and 11 never fires.
- R4: A flag set by an edge or by the set alias stays 1 until a clear-alias write with a 1 in that bit position.
- R5: When an edge on a pin is detected in the same cycle as a clear write to that pin's flag, the flag remains set.
- R6: irq_o is a register that takes the OR over all pins of (flag AND interrupt enable), so it follows the flags one clock later.
- R7: With the filter off, a new pin level sampled at a clock edge sets the flag at that same edge.
- R8: With the filter on, a level lasting one cycle never sets a flag, and a level lasting two cycles sets it two clock edges later than the unfiltered path would.
- R9: Turning a pin's filter enable on or off while its input is steady does not set its flag.
- R10: evt_o[i] is a one-cycle pulse, driven only when event-enable[i] is 1. It is produced by the mode-qualified edge, taken from the filtered level when event-filter-select[i] is 1 and from the raw level otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous-release reset |
| pin_i | input | NUM_PINS | Synchronized pin levels |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register and operation select |
| bus_wdata_i | input | NUM_PINS | Write data, one bit per pin |
| bus_rdata_o | output | NUM_PINS | Read data of the addressed register |
| irq_o | output | 1 | Combined interrupt request |
| evt_o | output | NUM_PINS | Per-pin one-cycle event pulses |

## Verification
The properties assume that pin_i is already synchronous to clk_i and is held low throughout reset. If a pin were high at reset release, the raw path would see a rising edge against the cleared history register. The stimulus therefore keeps every pin at 0 until reset is removed, and changes pins and bus signals only a short time after a rising edge. The properties also assume that a single write never targets both the set and the clear alias of the flags. The address decode guarantees this, and the bench issues at most one write per cycle.

// File: rtl/pinc_pkg.sv
package pinc_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_SET   = 2'd1,
    OP_CLEAR = 2'd2,
    OP_NOP   = 2'd3
  } reg_op_e;

  localparam int REG_FEN   = 0;
  localparam int REG_MODE0 = 1;
  localparam int REG_MODE1 = 2;
  localparam int REG_IEN   = 3;
  localparam int REG_EEN   = 4;
  localparam int REG_EFLT  = 5;
  localparam int REG_FLAG  = 6;
  localparam int NUM_CFG   = 6;

  // Trigger qualification: {hi,lo} 00 any, 01 rise, 10 fall, 11 none.
  function automatic logic edge_match(input logic mode_hi, input logic mode_lo,
                                      input logic rise, input logic fall);
    logic hit;
    case ({mode_hi, mode_lo})
      2'b00:   hit = rise | fall;
      2'b01:   hit = rise;
      2'b10:   hit = fall;
      default: hit = 1'b0;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/pinc_cfg_reg.sv
module pinc_cfg_reg
  import pinc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  reg_op_e      op_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] q_o
);

  function automatic logic [W-1:0] apply_op(input logic [W-1:0] cur,
                                            input logic [W-1:0] data,
                                            input reg_op_e op);
    logic [W-1:0] nxt;
    case (op)
      OP_WRITE: nxt = data;
      OP_SET:   nxt = cur | data;
      OP_CLEAR: nxt = cur & ~data;
      default:  nxt = cur;
    endcase
    return nxt;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (sel_i) q_o <= apply_op(q_o, wdata_i, op_i);
  end

endmodule

// File: rtl/pinc_glitch_filter.sv
module pinc_glitch_filter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] lvl_i,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);

  for (genvar g = 0; g < W; g++) begin : g_pin
    logic smp_a_q, smp_b_q, filt_q;
    logic settle;

    // Two equal consecutive samples are needed before the level moves.
    assign settle = (smp_a_q == smp_b_q);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        smp_a_q <= 1'b0;
        smp_b_q <= 1'b0;
        filt_q  <= 1'b0;
      end else begin
        smp_a_q <= lvl_i[g];
        smp_b_q <= smp_a_q;
        if (settle) filt_q <= smp_a_q;
      end
    end

    // Edge is seen in the cycle the filtered level is about to change.
    assign rise_o[g] = settle &  smp_a_q & ~filt_q;
    assign fall_o[g] = settle & ~smp_a_q &  filt_q;
  end

endmodule

// File: rtl/pinc_flag_bank.sv
module pinc_flag_bank
  import pinc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  reg_op_e      op_i,
  input  logic [W-1:0] wdata_i,
  input  logic [W-1:0] hit_i,
  output logic [W-1:0] flag_o
);

  logic [W-1:0] set_mask, clr_mask;

  assign set_mask = (sel_i && op_i == OP_SET)   ? wdata_i : '0;
  assign clr_mask = (sel_i && op_i == OP_CLEAR) ? wdata_i : '0;

  // Hardware edges are applied after the clear, so they win.
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_o <= '0;
    else         flag_o <= (flag_o & ~clr_mask) | set_mask | hit_i;
  end

endmodule

// File: rtl/pin_irq_conditioner.sv
module pin_irq_conditioner
  import pinc_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 5
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] pin_i,
  input  logic                bus_we_i,
  input  logic [ADDR_W-1:0]   bus_addr_i,
  input  logic [NUM_PINS-1:0] bus_wdata_i,
  output logic [NUM_PINS-1:0] bus_rdata_o,
  output logic                irq_o,
  output logic [NUM_PINS-1:0] evt_o
);

  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0]    reg_sel;
  reg_op_e             reg_op;
  logic [NUM_PINS-1:0] cfg_q [NUM_CFG];
  logic [NUM_PINS-1:0] fen_q, m0_q, m1_q, ien_q, een_q, eflt_q;
  logic [NUM_PINS-1:0] flag_q;
  logic [NUM_PINS-1:0] raw_prev_q, raw_rise, raw_fall;
  logic [NUM_PINS-1:0] flt_rise, flt_fall;
  logic [NUM_PINS-1:0] raw_hit, flt_hit, irq_hit, evt_hit;
  logic                flag_sel;

  assign reg_sel = bus_addr_i[ADDR_W-1:2];
  assign reg_op  = reg_op_e'(bus_addr_i[1:0]);

  // Configuration registers
  for (genvar r = 0; r < NUM_CFG; r++) begin : g_cfg
    pinc_cfg_reg #(.W(NUM_PINS)) cfg_i (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_i   (bus_we_i && reg_sel == SEL_W'(r)),
      .op_i    (reg_op),
      .wdata_i (bus_wdata_i),
      .q_o     (cfg_q[r])
    );
  end

  assign fen_q  = cfg_q[REG_FEN];
  assign m0_q   = cfg_q[REG_MODE0];
  assign m1_q   = cfg_q[REG_MODE1];
  assign ien_q  = cfg_q[REG_IEN];
  assign een_q  = cfg_q[REG_EEN];
  assign eflt_q = cfg_q[REG_EFLT];

  // Raw edge path: compare against last sampled level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) raw_prev_q <= '0;
    else         raw_prev_q <= pin_i;
  end

  assign raw_rise = pin_i & ~raw_prev_q;
  assign raw_fall = ~pin_i & raw_prev_q;

  // Filtered edge path
  pinc_glitch_filter #(.W(NUM_PINS)) filt_i (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .lvl_i  (pin_i),
    .rise_o (flt_rise),
    .fall_o (flt_fall)
  );

  // Per-pin qualification; each path keeps its own edge history, so
  // switching the selector never manufactures an edge.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_qual
    assign raw_hit[p] = edge_match(m1_q[p], m0_q[p], raw_rise[p], raw_fall[p]);
    assign flt_hit[p] = edge_match(m1_q[p], m0_q[p], flt_rise[p], flt_fall[p]);
    assign irq_hit[p] = fen_q[p]  ? flt_hit[p] : raw_hit[p];
    assign evt_hit[p] = eflt_q[p] ? flt_hit[p] : raw_hit[p];
  end

  // Sticky flags
  assign flag_sel = bus_we_i && reg_sel == SEL_W'(REG_FLAG);

  pinc_flag_bank #(.W(NUM_PINS)) flags_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .sel_i   (flag_sel),
    .op_i    (reg_op),
    .wdata_i (bus_wdata_i),
    .hit_i   (irq_hit),
    .flag_o  (flag_q)
  );

  // Registered outputs
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      evt_o <= '0;
    end else begin
      irq_o <= |(flag_q & ien_q);
      evt_o <= evt_hit & een_q;
    end
  end

  // Read mux
  always_comb begin
    bus_rdata_o = '0;
    if (reg_sel == SEL_W'(REG_FLAG)) bus_rdata_o = flag_q;
    for (int k = 0; k < NUM_CFG; k++) begin
      if (reg_sel == SEL_W'(k)) bus_rdata_o = cfg_q[k];
    end
  end

endmodule

// File: rtl/pinc_checker.sv
module pinc_checker
  import pinc_pkg::*;
#(
  parameter int NUM_PINS = 32,
  parameter int ADDR_W   = 5
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                bus_we_i,
  input logic [ADDR_W-1:0]   bus_addr_i,
  input logic [NUM_PINS-1:0] bus_wdata_i,
  input logic [NUM_PINS-1:0] flag_q,
  input logic [NUM_PINS-1:0] ien_q,
  input logic [NUM_PINS-1:0] een_q,
  input logic [NUM_PINS-1:0] m0_q,
  input logic [NUM_PINS-1:0] m1_q,
  input logic [NUM_PINS-1:0] irq_hit,
  input logic                irq_o,
  input logic [NUM_PINS-1:0] evt_o
);

  logic flag_reg_hit, clr_wr, set_wr;
  assign flag_reg_hit = bus_we_i && bus_addr_i[ADDR_W-1:2] == (ADDR_W-2)'(REG_FLAG);
  assign clr_wr = flag_reg_hit && bus_addr_i[1:0] == OP_CLEAR;
  assign set_wr = flag_reg_hit && bus_addr_i[1:0] == OP_SET;

  AST_FLAG_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_wr |=> ((flag_q & $past(flag_q)) == $past(flag_q))); // R4

  AST_FLAG_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> ((flag_q & $past(bus_wdata_i & ~irq_hit)) == '0)); // R4

  AST_EDGE_BEATS_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_wr |=> ((flag_q & $past(irq_hit)) == $past(irq_hit))); // R5

  AST_RSVD_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_wr |=> ((flag_q & ~$past(flag_q) & $past(m0_q & m1_q)) == '0)); // R3

  AST_IRQ_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(flag_q & ien_q)) |=> irq_o); // R6

  AST_IRQ_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(flag_q & ien_q)) |=> !irq_o); // R6

  AST_EVT_GATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (een_q == '0) |=> (evt_o == '0)); // R10

endmodule

bind pin_irq_conditioner pinc_checker #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) chk_i (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .bus_we_i    (bus_we_i),
  .bus_addr_i  (bus_addr_i),
  .bus_wdata_i (bus_wdata_i),
  .flag_q      (flag_q),
  .ien_q       (ien_q),
  .een_q       (een_q),
  .m0_q        (m0_q),
  .m1_q        (m1_q),
  .irq_hit     (irq_hit),
  .irq_o       (irq_o),
  .evt_o       (evt_o)
);

// File: tb/pin_irq_conditioner_tb.sv
module pin_irq_conditioner_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int NP = 32;
  localparam int AW = 5;
  localparam int NVEC = 12;

  // {address, write data, expected read-back of the same register}
  localparam logic [68:0] VEC [NVEC] = '{
    {5'h00, 32'h0000FFFF, 32'h0000FFFF},
    {5'h01, 32'h00F00000, 32'h00F0FFFF},
    {5'h02, 32'h0000000F, 32'h00F0FFF0},
    {5'h03, 32'hFFFFFFFF, 32'h00F0FFF0},
    {5'h00, 32'h00000000, 32'h00000000},
    {5'h0C, 32'hA5A5A5A5, 32'hA5A5A5A5},
    {5'h0E, 32'hFFFF0000, 32'h0000A5A5},
    {5'h0C, 32'h00000000, 32'h00000000},
    {5'h19, 32'h00000003, 32'h00000003},
    {5'h18, 32'hFFFFFFFF, 32'h00000003},
    {5'h1A, 32'h00000001, 32'h00000002},
    {5'h1A, 32'hFFFFFFFF, 32'h00000000}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NP-1:0] pins = '0;
  logic          bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [NP-1:0] bus_wdata = '0;
  logic [NP-1:0] bus_rdata;
  logic          irq;
  logic [NP-1:0] evt;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_conditioner #(.NUM_PINS(NP), .ADDR_W(AW)) dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .pin_i       (pins),
    .bus_we_i    (bus_we),
    .bus_addr_i  (bus_addr),
    .bus_wdata_i (bus_wdata),
    .bus_rdata_o (bus_rdata),
    .irq_o       (irq),
    .evt_o       (evt)
  );

  function automatic logic [AW-1:0] adr(input int r, input int op);
    return AW'(r * 4 + op);
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [NP-1:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    tick();
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [NP-1:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic chk(input string req, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_flags(input string req, input logic [NP-1:0] exp);
    logic [NP-1:0] v;
    rd(adr(6, 0), v);
    chk(req, v, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [NP-1:0] v;
    repeat (3) tick();
    rst_n = 1'b1;
    tick();

    // R1: reset state
    chk("R1 irq", NP'(irq), '0);
    chk("R1 evt", evt, '0);
    for (int r = 0; r < 8; r++) begin
      rd(adr(r, 0), v);
      chk("R1 reg", v, '0);
    end

    // R2: alias table
    for (int i = 0; i < NVEC; i++) begin
      wr(VEC[i][68:64], VEC[i][63:32]);
      rd(VEC[i][68:64], v);
      chk("R2 alias", v, VEC[i][31:0]);
    end

    // R3 / R7: modes pin0 any, pin1 rise, pin2 fall, pin3 reserved
    wr(adr(1, 0), 32'h0000000A);
    wr(adr(2, 0), 32'h0000000C);
    pins[3:0] = 4'hF;
    tick();
    chk_flags("R3 R7 rise", 32'h3);
    wr(adr(6, 2), 32'hF);
    chk_flags("R4 cleared", 32'h0);
    pins[3:0] = 4'h0;
    tick();
    chk_flags("R3 fall", 32'h5);
    wr(adr(6, 2), 32'hFFFFFFFF);

    // R6: registered interrupt gating
    wr(adr(3, 0), 32'h1);
    wr(adr(6, 1), 32'h2);
    tick();
    chk("R6 masked", NP'(irq), '0);
    wr(adr(6, 1), 32'h1);
    chk("R6 delay", NP'(irq), '0);
    tick();
    chk("R6 on", NP'(irq), NP'(1));
    wr(adr(6, 2), 32'h3);
    chk("R6 hold", NP'(irq), NP'(1));
    tick();
    chk("R6 off", NP'(irq), '0);
    wr(adr(3, 0), 32'h0);

    // R5: edge in the clear cycle wins, R4: clear alone works
    wr(adr(6, 1), 32'h1);
    pins[0] = 1'b1;
    bus_we = 1'b1; bus_addr = adr(6, 2); bus_wdata = 32'h1;
    tick();
    bus_we = 1'b0;
    chk_flags("R5 edge wins", 32'h1);
    wr(adr(6, 2), 32'h1);
    chk_flags("R4 w1c", 32'h0);
    pins[0] = 1'b0;
    tick();
    wr(adr(6, 2), 32'hFFFFFFFF);

    // R8: filter on pin4
    wr(adr(0, 0), 32'h10);
    pins[4] = 1'b1;
    tick();
    pins[4] = 1'b0;
    repeat (5) tick();
    chk_flags("R8 reject", 32'h0);
    pins[4] = 1'b1;
    tick();
    chk_flags("R8 lat1", 32'h0);
    tick();
    chk_flags("R8 lat2", 32'h0);
    pins[4] = 1'b0;
    tick();
    chk_flags("R8 accept", 32'h10);
    repeat (4) tick();
    wr(adr(6, 2), 32'hFFFFFFFF);

    // R9: filter toggle on a steady pin
    pins[5] = 1'b1;
    repeat (4) tick();
    wr(adr(6, 2), 32'hFFFFFFFF);
    wr(adr(0, 1), 32'h20);
    repeat (4) tick();
    chk_flags("R9 on", 32'h0);
    wr(adr(0, 2), 32'h20);
    repeat (4) tick();
    chk_flags("R9 off", 32'h0);

    // R10: event pulses, raw then filtered; pin7 not enabled
    wr(adr(4, 0), 32'h40);
    pins[6] = 1'b1;
    pins[7] = 1'b1;
    tick();
    chk("R10 raw pulse", evt, 32'h40);
    tick();
    chk("R10 raw end", evt, 32'h0);
    wr(adr(5, 1), 32'h40);
    repeat (3) tick();
    pins[6] = 1'b0;
    pins[7] = 1'b0;
    tick();
    chk("R10 flt c1", evt, 32'h0);
    tick();
    chk("R10 flt c2", evt, 32'h0);
    tick();
    chk("R10 flt pulse", evt, 32'h40);
    tick();
    chk("R10 flt end", evt, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule